// File: doc/BRIEF.md
# Bit Clock Phase Alignment Controller

The source-synchronous bit clock of a serial converter link arrives a quarter period away from its data and frame lanes. Once it has passed through on-chip routing and buffers it has to be moved again before it can capture those lanes. This controller drives the tap count of a 32-position variable delay placed in the bit clock path. A capture flop that runs on the delayed clock registers the undelayed bit clock as data. The level it captures at each tap shows which side of a clock edge the delayed clock is on.

When `start` is pulsed, the controller loads tap zero and steps the tap through every position. After each load it waits for the delay line to settle, then reads the captured level. It keeps the first confirmed rising edge and the first confirmed falling edge. A level change only counts as an edge when the level was steady for several reads before it and for several reads after it. From the edges it finds, the controller computes a final tap, loads it and raises `done_o`. If it finds no edge at all, it also raises `err_o` and leaves the tap at zero. The delay line and the capture flop are outside this block. The `samp_in` bit is assumed to be already in the controller's clock domain.

Top module: `bpa_phase_align`

## Requirements
- R1: After reset, `tap_o` is 0 and `tap_load_o`, `done_o` and `err_o` are all low.
- R2: A `start` pulse in idle or done begins a sweep. Each tap from 0 up to 31 is loaded in order as a one-cycle `tap_load_o` pulse. `tap_o` changes only in a cycle where `tap_load_o` is high.
- R3: After each load the controller waits 8 cycles before it samples. With default parameters, successive sweep loads are exactly 10 cycles apart, and `tap_load_o` is never high two cycles in a row.
- R4: A transition counts as an edge only when the level before it was read at 4 or more consecutive taps and the new level is then read at 4 consecutive taps. The edge tap is the first tap that reads the new level. A new level of 1 makes a rising edge and a new level of 0 makes a falling edge. Only the first edge of each kind is kept.
- R5: When both a rising edge and a falling edge are found, the final tap is floor((rise + fall) / 2).
- R6: When only one edge e is found, the final tap is e + 8 if that is at most 31. Otherwise it is e - 8.
- R7: When no edge is found, `err_o` goes high and the final load writes tap 0.
- R8: The final tap is loaded in the same cycle that `done_o` rises. `done_o` and `err_o` then hold until the next `start`. A `start` during a sweep is ignored.
- R9: `done_o` and `err_o` go low in the cycle after an accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel-rate controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Single-cycle request to run an alignment sweep |
| samp_in | input | 1 | Bit clock level captured by the delayed clock |
| tap_o | output | 5 | Tap count presented to the delay line |
| tap_load_o | output | 1 | One-cycle strobe that loads `tap_o` into the delay line |
| done_o | output | 1 | Alignment finished, final tap loaded |
| err_o | output | 1 | No clock edge was found during the sweep |

## Verification
The assertions assume three things about the inputs. `samp_in` is a fixed function of the most recently loaded tap and is steady by the end of each settle window. `start` is a one-cycle pulse. The delay line latches `tap_o` on the clock edge where it sees `tap_load_o`. The bench follows all three: its delay line model registers the tap on each load strobe and drives `samp_in` from a fixed 32-entry level pattern indexed by that tap. It changes `start` only on falling clock edges, one cycle at a time.

// File: rtl/bpa_pkg.sv
package bpa_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ZERO,
        ST_SETTLE,
        ST_SAMPLE,
        ST_STEP,
        ST_CALC,
        ST_DONE
    } bpa_state_e;
endpackage

// File: rtl/bpa_settle_timer.sv
module bpa_settle_timer #(
    parameter int SETTLE_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic expired
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);

    typedef struct packed {
        logic             running;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d   = tmr_q;
        expired = 1'b0;
        if (kick) begin
            tmr_d.running = 1'b1;
            tmr_d.cnt     = CNT_W'(SETTLE_CYC - 1);
        end else if (tmr_q.running) begin
            if (tmr_q.cnt == '0) begin
                expired       = 1'b1;
                tmr_d.running = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // The sequencer must not restart the wait while one is still running.
    assert_no_rekick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        kick |-> !tmr_q.running);
endmodule

// File: rtl/bpa_edge_finder.sv
module bpa_edge_finder #(
    parameter int TAP_W      = 5,
    parameter int STABLE_RUN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             smp_en,
    input  logic             smp_val,
    input  logic [TAP_W-1:0] cur_tap,
    output logic             rise_found,
    output logic [TAP_W-1:0] rise_tap,
    output logic             fall_found,
    output logic [TAP_W-1:0] fall_tap
);
    localparam int LEN_W = $clog2(STABLE_RUN + 1);
    localparam logic [LEN_W-1:0] RUN_FULL = LEN_W'(STABLE_RUN);

    typedef struct packed {
        logic             have;
        logic             run_val;
        logic [LEN_W-1:0] run_len;
        logic [LEN_W-1:0] pre_len;
        logic [TAP_W-1:0] cand;
        logic             rise_f;
        logic [TAP_W-1:0] rise_t;
        logic             fall_f;
        logic [TAP_W-1:0] fall_t;
    } ef_t;

    ef_t ef_d, ef_q;

    always_comb begin
        ef_d = ef_q;
        if (clr) begin
            ef_d = '0;
        end else if (smp_en) begin
            if (!ef_q.have) begin
                ef_d.have    = 1'b1;
                ef_d.run_val = smp_val;
                ef_d.run_len = LEN_W'(1);
                ef_d.pre_len = '0;
            end else if (smp_val == ef_q.run_val) begin
                if (ef_q.run_len < RUN_FULL) begin
                    ef_d.run_len = ef_q.run_len + 1'b1;
                    if (ef_q.run_len == RUN_FULL - 1'b1 && ef_q.pre_len == RUN_FULL) begin
                        if (smp_val && !ef_q.rise_f) begin
                            ef_d.rise_f = 1'b1;
                            ef_d.rise_t = ef_q.cand;
                        end
                        if (!smp_val && !ef_q.fall_f) begin
                            ef_d.fall_f = 1'b1;
                            ef_d.fall_t = ef_q.cand;
                        end
                    end
                end
            end else begin
                ef_d.pre_len = ef_q.run_len;
                ef_d.run_val = smp_val;
                ef_d.run_len = LEN_W'(1);
                ef_d.cand    = cur_tap;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ef_q <= '0;
        else        ef_q <= ef_d;
    end

    assign rise_found = ef_q.rise_f;
    assign rise_tap   = ef_q.rise_t;
    assign fall_found = ef_q.fall_f;
    assign fall_tap   = ef_q.fall_t;

    // A rising edge is only taken once a full run of ones has been seen.
    assert_rise_confirmed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ef_q.rise_f) |-> (ef_q.run_val && ef_q.run_len == RUN_FULL));
    assert_fall_confirmed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ef_q.fall_f) |-> (!ef_q.run_val && ef_q.run_len == RUN_FULL));
endmodule

// File: rtl/bpa_tap_calc.sv
module bpa_tap_calc #(
    parameter int TAP_W    = 5,
    parameter int EDGE_OFS = 8
) (
    input  logic             rise_found,
    input  logic [TAP_W-1:0] rise_tap,
    input  logic             fall_found,
    input  logic [TAP_W-1:0] fall_tap,
    output logic [TAP_W-1:0] fin_tap,
    output logic             no_edge
);
    localparam int LAST_TAP = (1 << TAP_W) - 1;

    logic [TAP_W:0]   sum;
    logic [TAP_W-1:0] one_edge;
    logic [TAP_W:0]   fwd;

    always_comb begin
        sum      = {1'b0, rise_tap} + {1'b0, fall_tap};
        one_edge = rise_found ? rise_tap : fall_tap;
        fwd      = {1'b0, one_edge} + (TAP_W + 1)'(EDGE_OFS);
        no_edge  = !rise_found && !fall_found;
        if (rise_found && fall_found)
            fin_tap = sum[TAP_W:1];
        else if (no_edge)
            fin_tap = '0;
        else if (fwd <= (TAP_W + 1)'(LAST_TAP))
            fin_tap = fwd[TAP_W-1:0];
        else
            fin_tap = one_edge - TAP_W'(EDGE_OFS);
    end
endmodule

// File: rtl/bpa_phase_align.sv
module bpa_phase_align #(
    parameter int TAP_W      = 5,
    parameter int SETTLE_CYC = 8,
    parameter int STABLE_RUN = 4,
    parameter int EDGE_OFS   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             samp_in,
    output logic [TAP_W-1:0] tap_o,
    output logic             tap_load_o,
    output logic             done_o,
    output logic             err_o
);
    import bpa_pkg::*;

    localparam int LAST_TAP = (1 << TAP_W) - 1;

    typedef struct packed {
        bpa_state_e       state;
        logic [TAP_W-1:0] tap;
        logic             load;
        logic             done;
        logic             err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             kick, expired, clr, smp_en;
    logic             rise_found, fall_found, no_edge;
    logic [TAP_W-1:0] rise_tap, fall_tap, fin_tap;

    bpa_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) settle_i (
        .clk(clk), .rst_n(rst_n), .kick(kick), .expired(expired)
    );

    bpa_edge_finder #(.TAP_W(TAP_W), .STABLE_RUN(STABLE_RUN)) edges_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .smp_en(smp_en),
        .smp_val(samp_in), .cur_tap(ctl_q.tap),
        .rise_found(rise_found), .rise_tap(rise_tap),
        .fall_found(fall_found), .fall_tap(fall_tap)
    );

    bpa_tap_calc #(.TAP_W(TAP_W), .EDGE_OFS(EDGE_OFS)) calc_i (
        .rise_found(rise_found), .rise_tap(rise_tap),
        .fall_found(fall_found), .fall_tap(fall_tap),
        .fin_tap(fin_tap), .no_edge(no_edge)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.load = 1'b0;
        kick       = 1'b0;
        clr        = 1'b0;
        smp_en     = 1'b0;
        case (ctl_q.state)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    ctl_d.state = ST_ZERO;
                    ctl_d.done  = 1'b0;
                    ctl_d.err   = 1'b0;
                    clr         = 1'b1;
                end
            end
            ST_ZERO: begin
                ctl_d.tap   = '0;
                ctl_d.load  = 1'b1;
                kick        = 1'b1;
                ctl_d.state = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (expired) ctl_d.state = ST_SAMPLE;
            end
            ST_SAMPLE: begin
                smp_en      = 1'b1;
                ctl_d.state = (ctl_q.tap == TAP_W'(LAST_TAP)) ? ST_CALC : ST_STEP;
            end
            ST_STEP: begin
                ctl_d.tap   = ctl_q.tap + 1'b1;
                ctl_d.load  = 1'b1;
                kick        = 1'b1;
                ctl_d.state = ST_SETTLE;
            end
            ST_CALC: begin
                ctl_d.tap   = fin_tap;
                ctl_d.load  = 1'b1;
                ctl_d.done  = 1'b1;
                ctl_d.err   = no_edge;
                ctl_d.state = ST_DONE;
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign tap_o      = ctl_q.tap;
    assign tap_load_o = ctl_q.load;
    assign done_o     = ctl_q.done;
    assign err_o      = ctl_q.err;

    assert_tap_only_on_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tap_o) |-> tap_load_o);
    assert_load_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tap_load_o |=> !tap_load_o);
    assert_err_tap_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (done_o && tap_o == '0));
    assert_done_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start) |=> done_o);
    assert_done_with_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> tap_load_o);
endmodule

// File: tb/bpa_phase_align_tb.sv
module bpa_phase_align_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       samp_in;
    logic [4:0] tap_o;
    logic       tap_load_o, done_o, err_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    bpa_phase_align dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .samp_in(samp_in),
        .tap_o(tap_o), .tap_load_o(tap_load_o), .done_o(done_o), .err_o(err_o)
    );

    // Delay line and capture model.
    logic [31:0] pat = '0;
    logic [4:0]  line_tap = '0;
    always @(posedge clk) if (tap_load_o) line_tap <= tap_o;
    assign samp_in = pat[line_tap];

    typedef struct packed {
        logic [4:0] tap;
        logic       err;
    } exp_t;
    exp_t exp_q[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor state for sweep order and spacing.
    int  cyc = 0;
    int  seq_idx = 0;
    int  last_cyc = 0;
    bit  seq_ok = 1'b1;
    logic [4:0] prev_tap = '0;
    logic       prev_done = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (tap_load_o) begin
                if (seq_idx < 32) begin
                    if (tap_o != 5'(seq_idx)) seq_ok = 1'b0;
                    if (seq_idx > 0 && cyc - last_cyc != 10) seq_ok = 1'b0;
                end
                last_cyc = cyc;
                seq_idx++;
            end else if (tap_o != prev_tap) begin
                seq_ok = 1'b0;
            end
            if (done_o && !prev_done) begin
                exp_t e;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected done", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(tap_o == e.tap, "R5/R6/R7 final tap", tap_o, e.tap);
                    chk(err_o == e.err, "R7 error flag", err_o, e.err);
                    chk(tap_load_o, "R8 load with done", tap_load_o, 1);
                    chk(seq_ok && seq_idx == 33, "R2/R3 sweep order and spacing", seq_idx, 33);
                end
            end
        end
        prev_tap  = tap_o;
        prev_done = done_o;
    end

    function automatic logic [31:0] seg3(input bit v0, input int a, input int b);
        logic [31:0] p;
        for (int t = 0; t < 32; t++) p[t] = (t >= a && t < b) ? ~v0 : v0;
        return p;
    endfunction

    task automatic run_case(input logic [31:0] p, input logic [4:0] et, input bit ee,
                            input bit poke, input string req);
        exp_t e;
        int waited;
        @(negedge clk);
        pat = p;
        e.tap = et;
        e.err = ee;
        exp_q.push_back(e);
        seq_idx = 0;
        seq_ok  = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!done_o && !err_o, "R9 flags cleared by start", done_o, 0);
        if (poke) begin
            repeat (150) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (!done_o && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        chk(done_o, {req, " done reached"}, done_o, 1);
        repeat (5) @(negedge clk);
        chk(done_o && err_o == ee && tap_o == et, "R8 result held", tap_o, et);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] g;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tap_o == 0 && !tap_load_o && !done_o && !err_o, "R1 reset state", tap_o, 0);

        run_case(seg3(1'b0, 10, 26), 5'd18, 1'b0, 1'b0, "R5 rise10 fall26");
        run_case(seg3(1'b1, 6, 22),  5'd14, 1'b0, 1'b0, "R5 fall6 rise22");
        run_case(seg3(1'b0, 20, 32), 5'd28, 1'b0, 1'b0, "R6 rise only fwd");
        run_case(seg3(1'b0, 28, 32), 5'd20, 1'b0, 1'b0, "R6 rise only back");
        run_case(seg3(1'b1, 12, 32), 5'd20, 1'b0, 1'b0, "R6 fall only");
        run_case(seg3(1'b0, 32, 32), 5'd0,  1'b1, 1'b0, "R7 flat");
        g = seg3(1'b0, 10, 32);
        g[4] = 1'b1;
        run_case(g,                  5'd18, 1'b0, 1'b0, "R4 glitch rejected");
        run_case(seg3(1'b0, 30, 32), 5'd0,  1'b1, 1'b0, "R4 short tail run");
        run_case(seg3(1'b0, 10, 26), 5'd18, 1'b0, 1'b1, "R8 start ignored mid sweep");

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R8 all results seen", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule